// File: doc/BRIEF.md
# I2C Master Transfer Sequencer

This block drives the master side of a two-wire serial bus. Software-level request inputs ask for a START, a STOP, a byte write or a byte read. The block produces SCL from a programmable divider and shapes SDA into START, repeated START and STOP conditions. It shifts a byte out or in, most significant bit first, and handles the acknowledge bit in the ninth clock.

A 4-bit state code and a 4-bit substate code are reported at all times. After each START or byte, the block holds SCL low and waits for the next request. If the addressed device refuses a written byte, the block parks in a wait state. It leaves that state only for a START or a STOP.

Top module: `i2c_mstr_seq`

## Requirements
- R1: After reset the state is 0000 with substate 0, and SCL and SDA are both released high. In this idle state a write or read request has no effect, and only a START request is accepted.
- R2: A START request from idle enters state 0101 at substate 2, with SCL=1 and SDA=0, for one high period. The block then goes to substate 3, where SCL=0 and SDA=0, and waits for a request.
- R3: A STOP request enters state 0110. In substate 0 it drives SCL=0, SDA=0 for one low period. In substate 1 it drives SCL=1, SDA=0 for one high period. It then moves to state 0100 with SCL=1, SDA=1 for one high period, and then to 0000. Idle is reached only from 0100.
- R4: A write request enters state 1100 and sends `tx_data_i` MSB first, one bit per SCL pulse. Substates 0..7 are the data bits, 8 is the acknowledge, and 9 is the SCL-low hold after the byte.
- R5: In a write, if SDA reads 1 (NACK) at the end of the acknowledge high phase, the block enters state 0111 with SCL low. There, write and read requests are ignored. It leaves only on START, which goes directly to 0101 substate 0 with no STOP, or on STOP, which goes to 0110.
- R6: A read request enters state 1101 and shifts in 8 bits MSB first onto `rx_data_o`. In the acknowledge clock the master drives SDA=0. It drives SDA=1 instead when `last_i` was high with the read request.
- R7: In data states, each SCL high phase lasts `div_hi_i` clocks and each low phase lasts `div_lo_i` clocks, with 0 treated as 1. A whole byte takes 9*(high+low) clocks, counted from the cycle the request is taken to the `done_o` pulse.
- R8: During data states, SDA changes only while SCL is low.
- R9: A START request from a hold substate gives a repeated START in state 0101. Substate 0 drives SCL=0, SDA=1 for one low period. Substate 1 drives SCL=1, SDA=1 for one high period. Substate 2 drives SCL=1, SDA=0. No STOP state is visited.
- R10: `done_o` is a one-cycle pulse at the end of each acknowledge clock. `ack_o` holds the SDA value sampled there, where 0 means ACK.
- R11: When several requests arrive together in a hold substate, the order of precedence is STOP, then START, then write, then read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_req_i | input | 1 | Request START or repeated START |
| stop_req_i | input | 1 | Request STOP |
| wr_req_i | input | 1 | Request a byte write |
| rd_req_i | input | 1 | Request a byte read |
| last_i | input | 1 | With rd_req_i: answer the byte with NACK |
| tx_data_i | input | DATA_W | Byte to transmit |
| div_hi_i | input | DIV_W | SCL high phase length in clocks |
| div_lo_i | input | DIV_W | SCL low phase length in clocks |
| sda_i | input | 1 | Sampled SDA bus level |
| scl_o | output | 1 | SCL level (1 = released) |
| sda_o | output | 1 | SDA level driven (1 = released) |
| rx_data_o | output | DATA_W | Last received byte |
| done_o | output | 1 | Byte complete pulse |
| ack_o | output | 1 | Acknowledge bit sampled in the last byte |
| state_o | output | 4 | State code |
| sub_o | output | 4 | Substate code |

## Verification
The bench stresses the zero divider setting and the exact byte duration. A divider that did not clamp zero, or that added a cycle per phase, would show as a wrong clock count or a wrong high-phase width. It refuses a written byte and then sends write, read and START requests to the wait state. A design that leaked out of the wait state, or that placed a STOP before the repeated START, would report the wrong state code. It also sends simultaneous requests to expose a wrong precedence, and it reads back every bit on the bus, which catches a reversed bit order or an acknowledge driven at the wrong level.

// File: rtl/i2c_mstr_pkg.sv
package i2c_mstr_pkg;
  typedef enum logic [3:0] {
    ST_IDLE  = 4'h0,
    ST_STOP2 = 4'h4,
    ST_START = 4'h5,
    ST_STOP1 = 4'h6,
    ST_WAIT  = 4'h7,
    ST_TX    = 4'hC,
    ST_RX    = 4'hD
  } mst_state_e;

  localparam int SUB_W = 4;
  localparam logic [SUB_W-1:0] SUB_RS_LO = 4'd0;
  localparam logic [SUB_W-1:0] SUB_RS_HI = 4'd1;
  localparam logic [SUB_W-1:0] SUB_START = 4'd2;
  localparam logic [SUB_W-1:0] SUB_SHOLD = 4'd3;
endpackage

// File: rtl/i2c_mstr_tmr.sv
module i2c_mstr_tmr #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             hi_sel_i,
  input  logic [DIV_W-1:0] div_hi_i,
  input  logic [DIV_W-1:0] div_lo_i,
  output logic             done_o
);
  logic [DIV_W-1:0] cnt_q, lim, lim_m1;

  always_comb begin
    lim    = hi_sel_i ? div_hi_i : div_lo_i;
    lim_m1 = (lim == '0) ? '0 : lim - DIV_W'(1);  // zero acts as one
  end

  assign done_o = run_i && (cnt_q == lim_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!run_i || done_o) cnt_q <= '0;
    else                      cnt_q <= cnt_q + DIV_W'(1);
  end

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> cnt_q <= lim_m1);  // R7
endmodule

// File: rtl/i2c_mstr_shreg.sv
module i2c_mstr_shreg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] data_o,
  output logic         msb_o
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (load_i)  sr_q <= data_i;
    else if (shift_i) sr_q <= {sr_q[W-2:0], bit_i};
  end

  assign data_o = sr_q;
  assign msb_o  = sr_q[W-1];

  AST_NO_LOAD_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_i && shift_i));  // R4
endmodule

// File: rtl/i2c_mstr_seq.sv
module i2c_mstr_seq
  import i2c_mstr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_req_i,
  input  logic              stop_req_i,
  input  logic              wr_req_i,
  input  logic              rd_req_i,
  input  logic              last_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic [DIV_W-1:0]  div_hi_i,
  input  logic [DIV_W-1:0]  div_lo_i,
  input  logic              sda_i,
  output logic              scl_o,
  output logic              sda_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              done_o,
  output logic              ack_o,
  output logic [3:0]        state_o,
  output logic [3:0]        sub_o
);
  localparam logic [SUB_W-1:0] SUB_ACK  = SUB_W'(DATA_W);
  localparam logic [SUB_W-1:0] SUB_HOLD = SUB_W'(DATA_W + 1);

  mst_state_e       st_q, st_d;
  logic [SUB_W-1:0] sub_q, sub_d;
  logic             ph_q, ph_d, last_q, last_d, ack_q, ack_d, done_q, done_d;
  logic             run, hi_sel, tdone, sr_ld, sr_sh, sr_msb;
  logic             is_data, hold;

  i2c_mstr_tmr #(.DIV_W(DIV_W)) u_tmr (
    .clk_i, .rst_ni, .run_i(run), .hi_sel_i(hi_sel),
    .div_hi_i, .div_lo_i, .done_o(tdone)
  );

  i2c_mstr_shreg #(.W(DATA_W)) u_sr (
    .clk_i, .rst_ni, .load_i(sr_ld), .data_i(tx_data_i),
    .shift_i(sr_sh), .bit_i(sda_i), .data_o(rx_data_o), .msb_o(sr_msb)
  );

  assign is_data = (st_q == ST_TX) || (st_q == ST_RX);
  assign hold    = (st_q == ST_START && sub_q == SUB_SHOLD) ||
                   (is_data && sub_q == SUB_HOLD);

  // line levels and timer phase
  always_comb begin
    scl_o = 1'b0; sda_o = 1'b1; run = 1'b0; hi_sel = 1'b0;
    unique case (st_q)
      ST_IDLE: scl_o = 1'b1;
      ST_START: begin
        unique case (sub_q)
          SUB_RS_LO: run = 1'b1;
          SUB_RS_HI: begin scl_o = 1'b1; run = 1'b1; hi_sel = 1'b1; end
          SUB_START: begin scl_o = 1'b1; sda_o = 1'b0; run = 1'b1; hi_sel = 1'b1; end
          default:   sda_o = 1'b0;
        endcase
      end
      ST_STOP1: begin
        sda_o = 1'b0; run = 1'b1;
        if (sub_q != '0) begin scl_o = 1'b1; hi_sel = 1'b1; end
      end
      ST_STOP2: begin scl_o = 1'b1; run = 1'b1; hi_sel = 1'b1; end
      ST_TX, ST_RX: begin
        if (sub_q != SUB_HOLD) begin
          run = 1'b1; scl_o = ph_q; hi_sel = ph_q;
        end
        if (sub_q < SUB_ACK) sda_o = (st_q == ST_TX) ? sr_msb : 1'b1;
        else                 sda_o = (st_q == ST_TX) ? 1'b1 : last_q;
      end
      default: ;
    endcase
  end

  always_comb begin
    st_d = st_q; sub_d = sub_q; ph_d = ph_q; last_d = last_q; ack_d = ack_q;
    done_d = 1'b0; sr_ld = 1'b0; sr_sh = 1'b0;
    if (hold || st_q == ST_WAIT) begin
      // precedence: stop, start, write, read
      if (stop_req_i) begin
        st_d = ST_STOP1; sub_d = '0; ph_d = 1'b0;
      end else if (start_req_i) begin
        st_d = ST_START; sub_d = SUB_RS_LO; ph_d = 1'b0;
      end else if (hold && wr_req_i) begin
        st_d = ST_TX; sub_d = '0; ph_d = 1'b0; sr_ld = 1'b1;
      end else if (hold && rd_req_i) begin
        st_d = ST_RX; sub_d = '0; ph_d = 1'b0; last_d = last_i;
      end
    end else if (st_q == ST_IDLE) begin
      if (start_req_i) begin st_d = ST_START; sub_d = SUB_START; end
    end else if (tdone) begin
      unique case (st_q)
        ST_START: sub_d = sub_q + 4'd1;
        ST_STOP1: begin
          if (sub_q == '0) sub_d = 4'd1;
          else begin st_d = ST_STOP2; sub_d = '0; end
        end
        ST_STOP2: begin st_d = ST_IDLE; sub_d = '0; end
        ST_TX, ST_RX: begin
          if (!ph_q) ph_d = 1'b1;
          else begin
            ph_d = 1'b0;
            if (sub_q != SUB_ACK) begin
              sr_sh = 1'b1; sub_d = sub_q + 4'd1;
            end else begin
              done_d = 1'b1; ack_d = sda_i;
              if (st_q == ST_TX && sda_i) begin st_d = ST_WAIT; sub_d = '0; end
              else sub_d = SUB_HOLD;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; sub_q <= '0; ph_q <= 1'b0;
      last_q <= 1'b0; ack_q <= 1'b0; done_q <= 1'b0;
    end else begin
      st_q <= st_d; sub_q <= sub_d; ph_q <= ph_d;
      last_q <= last_d; ack_q <= ack_d; done_q <= done_d;
    end
  end

  assign done_o  = done_q;
  assign ack_o   = ack_q;
  assign state_o = st_q;
  assign sub_o   = sub_q;

  AST_NACK_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_TX && ph_q && sub_q == SUB_ACK && tdone && sda_i) |=> st_q == ST_WAIT);  // R5
  AST_WAIT_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAIT) |=> (st_q inside {ST_WAIT, ST_START, ST_STOP1}));  // R5
  AST_IDLE_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE && st_q != ST_STOP2) |=> st_q != ST_IDLE);  // R3
  AST_SDA_HI_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_data && scl_o) |=> (!scl_o || $stable(sda_o)));  // R8
  AST_SUB_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_data |-> sub_q <= SUB_HOLD);  // R4
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);  // R10
endmodule

// File: tb/i2c_mstr_seq_bench.sv
`timescale 1ns/1ps
module i2c_mstr_seq_bench;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        start_req = 0, stop_req = 0, wr_req = 0, rd_req = 0, last = 0;
  logic [7:0]  tx_data = '0;
  logic [15:0] div_hi = 16'd2, div_lo = 16'd3;
  logic        scl, sda_drv, done, ack;
  logic [7:0]  rx_data;
  logic [3:0]  state, sub;
  logic [7:0]  cur_rx = '0;
  logic        slave_nack = 1'b0;
  logic        slave_sda, sda_bus;
  int          nchk = 0, nfail = 0;
  logic        fin = 1'b0;

  always #2.5 clk = ~clk;

  assign slave_sda = (state == 4'hD && sub < 4'd8) ? cur_rx[3'(4'd7 - sub)] :
                     (state == 4'hC && sub == 4'd8) ? ~slave_nack ? 1'b0 : 1'b1 : 1'b1;
  assign sda_bus = sda_drv & slave_sda;

  i2c_mstr_seq u_i2c_mstr_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_req_i(start_req), .stop_req_i(stop_req),
    .wr_req_i(wr_req), .rd_req_i(rd_req), .last_i(last), .tx_data_i(tx_data),
    .div_hi_i(div_hi), .div_lo_i(div_lo), .sda_i(sda_bus), .scl_o(scl),
    .sda_o(sda_drv), .rx_data_o(rx_data), .done_o(done), .ack_o(ack),
    .state_o(state), .sub_o(sub)
  );

  // bus monitor: bits at SCL rise, high-phase width in data states
  logic       scl_prev = 1'b1;
  logic [8:0] cap = '0;
  int         hi_run = 0, hi_len = 0;
  always @(negedge clk) begin
    scl_prev <= scl;
    if (scl && !scl_prev) cap <= {cap[7:0], sda_bus};
    if (scl) hi_run <= hi_run + 1;
    else begin
      if (scl_prev && (state == 4'hC || state == 4'hD)) hi_len <= hi_run;
      hi_run <= 0;
    end
  end

  typedef struct packed {
    logic       rx;
    logic       flag;
    logic [7:0] hi;
    logic [7:0] lo;
    logic [7:0] data;
  } vec_t;
  localparam vec_t VEC [0:5] = '{
    '{1'b0, 1'b0, 8'd2, 8'd3, 8'hA5},
    '{1'b0, 1'b1, 8'd1, 8'd1, 8'h3C},
    '{1'b1, 1'b0, 8'd3, 8'd2, 8'hC6},
    '{1'b1, 1'b1, 8'd1, 8'd4, 8'h81},
    '{1'b0, 1'b0, 8'd0, 8'd2, 8'hFF},
    '{1'b1, 1'b0, 8'd2, 8'd0, 8'h5A}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic s, input logic p, input logic w, input logic r);
    @(negedge clk);
    start_req = s; stop_req = p; wr_req = w; rd_req = r;
    @(negedge clk);
    start_req = 0; stop_req = 0; wr_req = 0; rd_req = 0;
  endtask

  task automatic wait_for(input logic [3:0] st, input logic [3:0] sb, input string req);
    int n = 0;
    while (!(state == st && sub == sb) && n < 5000) begin @(negedge clk); n++; end
    chk(req, {state, sub}, {st, sb});
  endtask

  task automatic xfer(input vec_t v);
    int n = 0;
    int h = (v.hi == 0) ? 1 : int'(v.hi);
    int l = (v.lo == 0) ? 1 : int'(v.lo);
    div_hi = 16'(v.hi); div_lo = 16'(v.lo);
    tx_data = v.data; cur_rx = v.data; slave_nack = v.flag; last = v.flag;
    cmd(1, 0, 0, 0);
    wait_for(4'h5, 4'd3, "R2 hold after START");
    cmd(0, 0, !v.rx, v.rx);
    while (!done && n < 5000) begin @(negedge clk); n++; end
    chk("R7 byte length", n, 9 * (h + l));
    chk("R7 high phase width", hi_len, h);
    chk(v.rx ? "R6 rx bits MSB first" : "R4 tx bits MSB first", cap[8:1], v.data);
    chk(v.rx ? "R6 master ack level" : "R10 slave ack on bus", cap[0], v.flag);
    chk("R10 ack_o", ack, v.flag);
    if (v.rx) chk("R6 rx_data_o", rx_data, v.data);
    chk(v.rx ? "R6 state after byte" : (v.flag ? "R5 NACK to wait" : "R4 hold after byte"),
        {state, sub}, (!v.rx && v.flag) ? 8'h70 : {v.rx ? 4'hD : 4'hC, 4'd9});
    @(negedge clk);
    chk("R10 done one cycle", done, 1'b0);
    cmd(0, 1, 0, 0);
    wait_for(4'h0, 4'd0, "R3 back to idle");
  endtask

  initial begin
    #(5.0 * 150000);
    if (!fin) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset state", {state, sub}, 8'h00);
    chk("R1 reset lines", {scl, sda_drv, done}, 3'b110);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 write/read ignored in idle
    cmd(0, 0, 1, 1);
    repeat (4) @(negedge clk);
    chk("R1 requests ignored in idle", {state, scl, sda_drv}, {4'h0, 2'b11});

    for (int i = 0; i < 6; i++) xfer(VEC[i]);

    // R2 START timing from idle, R9 repeated START
    div_hi = 16'd2; div_lo = 16'd3;
    cmd(1, 0, 0, 0);
    chk("R2 START condition", {state, sub, scl, sda_drv}, {8'h52, 2'b10});
    repeat (2) @(negedge clk);
    chk("R2 START hold", {state, sub, scl, sda_drv}, {8'h53, 2'b00});
    cmd(1, 0, 0, 0);
    chk("R9 restart sub0", {state, sub, scl, sda_drv}, {8'h50, 2'b01});
    repeat (3) @(negedge clk);
    chk("R9 restart sub1", {state, sub, scl, sda_drv}, {8'h51, 2'b11});
    repeat (2) @(negedge clk);
    chk("R9 restart sub2", {state, sub, scl, sda_drv}, {8'h52, 2'b10});
    repeat (2) @(negedge clk);
    // R11 STOP wins over START and write; R3 STOP phases
    cmd(1, 1, 1, 0);
    chk("R11 stop first", {state, sub, scl, sda_drv}, {8'h60, 2'b00});
    repeat (3) @(negedge clk);
    chk("R3 stop sub1", {state, sub, scl, sda_drv}, {8'h61, 2'b10});
    repeat (2) @(negedge clk);
    chk("R3 stop2", {state, scl, sda_drv}, {4'h4, 2'b11});
    repeat (2) @(negedge clk);
    chk("R3 idle after stop", {state, scl, sda_drv}, {4'h0, 2'b11});

    // R11 START over write, write over read
    cmd(1, 0, 0, 0);
    wait_for(4'h5, 4'd3, "R2 hold");
    cmd(1, 0, 1, 1);
    chk("R11 start over write", {state, sub}, 8'h50);
    wait_for(4'h5, 4'd3, "R9 hold after restart");
    tx_data = 8'h96; slave_nack = 1'b1;
    cmd(0, 0, 1, 1);
    chk("R11 write over read", state, 4'hC);
    wait_for(4'h7, 4'd0, "R5 NACK wait");
    // R5 write/read ignored in wait
    cmd(0, 0, 1, 1);
    repeat (6) @(negedge clk);
    chk("R5 wait ignores write/read", {state, scl}, {4'h7, 1'b0});
    cmd(1, 0, 0, 0);
    chk("R5 restart from wait skips STOP", {state, sub, scl, sda_drv}, {8'h50, 2'b01});
    wait_for(4'h5, 4'd3, "R9 hold");
    cmd(0, 1, 0, 0);
    wait_for(4'h0, 4'd0, "R3 idle");

    fin = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule